// File: doc/BRIEF.md
# Dual-Clock FIFO with One Reserved Slot

This block carries a stream of data words from one clock domain into a second domain whose clock has no fixed frequency or phase relation to the first. The producer drives a write enable and a word on its own clock and watches a full flag. The consumer drives a read enable on its own clock and watches an empty flag. A dual-port storage array sits between the two sides.

Each side keeps a plain binary pointer. The pointer is turned into Gray code and registered in its home domain. It then passes through a two-flop synchronizer in the far domain and is decoded back to binary there. Each flag is computed only from the local pointer and the decoded copy of the far pointer. One location is always left unused, so equal pointers always mean empty and never mean full. The flags can be pessimistic for a few cycles after the far side moves. The FIFO never loses or invents a word. The full flag clears only on write clock edges, so the write clock must keep running while full is high.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with no loss and no duplication. A write is accepted on a write clock edge where wr_en is 1 and wr_full is 0.
- R2: While arst_n is low and after it is released, rd_empty is 1, wr_full is 0 and rd_data is 0 until the first accepted read.
- R3: A write request while wr_full is 1 has no effect. Starting from empty with no reads, exactly DEPTH-1 writes (15 by default) are accepted, and later writes are dropped.
- R4: A read request while rd_empty is 1 has no effect: rd_data keeps its value and no word is consumed. rd_data changes only after an accepted read.
- R5: wr_full is 1 once DEPTH-1 words are stored and no read has happened, so one location stays unused.
- R6: rd_empty is 1 once every stored word has been read.
- R7: rd_data is registered. It shows the word read by an accepted read from the read clock edge that accepts it onward.
- R8: The Gray-coded copy of each pointer changes in at most one bit per clock of its home domain.
- R9: After a write into an empty FIFO, rd_empty falls within 6 read clock cycles. After reads from a full FIFO, wr_full falls while the write clock runs.
- R10: Reads and writes may proceed at the same time from both sides, and every word still arrives in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset, synchronized into each domain |
| wr_clk | input | 1 | Write domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | FIFO full, write domain |
| rd_clk | input | 1 | Read domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | FIFO empty, read domain |

## Verification
A write and a read can be accepted in the same instant on the two clocks. The write moves the empty/full picture that the read side sees, and the read moves the picture that the write side sees, each through the synchronizer. The bench provokes this by running both ports together with pseudo-random gaps at unrelated clock periods, so the flags toggle near both boundaries. Every accepted word goes into a scoreboard queue and is compared in order when it appears. Requests refused because of a flag must leave rd_data unchanged and must never show up in the output.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  // number of flip-flops in each pointer synchronizer
  localparam int SYNC_STAGES = 2;
  // number of flip-flops in each reset synchronizer
  localparam int RST_STAGES  = 2;
endpackage

// File: rtl/xclk_rst_sync.sv
module xclk_rst_sync
  import xclk_fifo_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [RST_STAGES-1:0] chain_q;
  logic [RST_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[RST_STAGES-1];
endmodule

// File: rtl/xclk_ptr_cross.sv
module xclk_ptr_cross
  import xclk_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [AW-1:0] src_bin,
  output logic [AW-1:0] src_gray,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic [AW-1:0] dst_bin
);
  logic [AW-1:0] gray_d;
  logic [AW-1:0] gray_q;
  logic [AW-1:0] stage_q [SYNC_STAGES];
  logic [AW-1:0] synced;

  always_comb begin
    gray_d = src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= gray_d;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= gray_q;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign synced = stage_q[SYNC_STAGES-1];

  // Gray back to binary: each bit is the XOR of all Gray bits at or above it
  genvar b;
  generate
    for (b = 0; b < AW; b++) begin : g_dec
      assign dst_bin[b] = ^(synced >> b);
    end
  endgenerate

  assign src_gray = gray_q;
endmodule

// File: rtl/xclk_store.sv
module xclk_store #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wr_clk,
  input  logic          wr_we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_word,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_re,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] rd_word_d;

  always_ff @(posedge wr_clk) begin
    if (wr_we) cells[wr_addr] <= wr_word;
  end

  always_comb begin
    rd_word_d = rd_re ? cells[rd_addr] : rd_word;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_word <= '0;
    else           rd_word <= rd_word_d;
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              arst_n,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  logic wr_rst_n, rd_rst_n;
  logic [ADDR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [ADDR_W-1:0] rptr_in_wr, wptr_in_rd;
  logic [ADDR_W-1:0] wgray_q, rgray_q;
  logic wr_take, rd_take;

  xclk_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(arst_n), .rst_n(wr_rst_n));
  xclk_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(arst_n), .rst_n(rd_rst_n));

  // write side: full when one step ahead of the synchronized read pointer
  always_comb begin
    wr_full = ((wptr_q + 1'b1) == rptr_in_wr);
    wr_take = wr_en && !wr_full;
    wptr_d  = wr_take ? wptr_q + 1'b1 : wptr_q;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) wptr_q <= '0;
    else           wptr_q <= wptr_d;
  end

  // read side: empty when equal to the synchronized write pointer
  always_comb begin
    rd_empty = (rptr_q == wptr_in_rd);
    rd_take  = rd_en && !rd_empty;
    rptr_d   = rd_take ? rptr_q + 1'b1 : rptr_q;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rptr_q <= '0;
    else           rptr_q <= rptr_d;
  end

  xclk_ptr_cross #(.AW(ADDR_W)) u_w2r (
    .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_bin(wptr_q), .src_gray(wgray_q),
    .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .dst_bin(wptr_in_rd)
  );

  xclk_ptr_cross #(.AW(ADDR_W)) u_r2w (
    .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_bin(rptr_q), .src_gray(rgray_q),
    .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(rptr_in_wr)
  );

  xclk_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .wr_clk(wr_clk), .wr_we(wr_take), .wr_addr(wptr_q), .wr_word(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_re(rd_take), .rd_addr(rptr_q),
    .rd_word(rd_data)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_n,
  input logic              rd_rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wr_full,
  input logic              rd_empty,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] wptr,
  input logic [ADDR_W-1:0] rptr,
  input logic [ADDR_W-1:0] wgray,
  input logic [ADDR_W-1:0] rgray
);
  // R3: refused write leaves the write pointer in place
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> $stable(wptr));

  // R4: refused read leaves pointer and read data in place
  a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> ($stable(rptr) && $stable(rd_data)));

  // R1: accepted write advances the pointer by one
  a_r1_wptr_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && !wr_full) |=> (wptr - $past(wptr)) == ADDR_W'(1));

  // R1: accepted read advances the pointer by one
  a_r1_rptr_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && !rd_empty) |=> (rptr - $past(rptr)) == ADDR_W'(1));

  // R8: Gray copies change in at most one bit per home clock
  a_r8_wgray_onebit: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r8_rgray_onebit: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind xclk_fifo xclk_fifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_en(wr_en), .rd_en(rd_en), .wr_full(wr_full), .rd_empty(rd_empty),
  .rd_data(rd_data), .wptr(wptr_q), .rptr(rptr_q), .wgray(wgray_q), .rgray(rgray_q)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic arst_n, wr_clk, rd_clk, wr_en, rd_en, wr_full, rd_empty;
  logic [DW-1:0] wr_data, rd_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_q [$];
  bit rst_done = 0, rd_go = 0, rd_rand = 0;
  int got = 0;

  xclk_fifo #(.ADDR_W(AW), .DATA_W(DW)) u_xclk_fifo (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  initial wr_clk = 0;
  always #2.5 wr_clk = ~wr_clk;
  initial rd_clk = 0;
  always #3.7 rd_clk = ~rd_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // write driver: one request per write clock; pushes accepted words
  task automatic wr_try(input logic [DW-1:0] d, output bit acc);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    acc = !wr_full;
    if (acc) exp_q.push_back(d);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  // read monitor / scoreboard
  initial begin
    bit pend = 0;
    logic [DW-1:0] expv = '0;
    logic [DW-1:0] last = '0;
    logic [15:0] lf = 16'hACE1;
    rd_en = 0;
    forever begin
      @(negedge rd_clk);
      if (rst_done) begin
        if (pend) begin
          chk(rd_data === expv, "R1/R7 read word", rd_data, expv);
          got++;
        end else begin
          chk(rd_data === last, "R4 rd_data held", rd_data, last);
        end
        last = rd_data;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rd_en = rd_go && (!rd_rand || lf[0]);
        pend = rd_en && !rd_empty;
        if (pend) begin
          if (exp_q.size() == 0) begin
            chk(0, "R4 underflow", 1, 0);
            pend = 0;
          end else expv = exp_q.pop_front();
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge wr_clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit acc;
    int nacc;
    int lat;
    logic [15:0] lw = 16'h1D2B;
    arst_n = 0; wr_en = 0; wr_data = '0;
    repeat (4) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R2 empty in reset", rd_empty, 1);
    chk(wr_full === 1'b0, "R2 full in reset", wr_full, 0);
    arst_n = 1;
    repeat (6) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R2 empty after reset", rd_empty, 1);
    chk(wr_full === 1'b0, "R2 full after reset", wr_full, 0);
    chk(rd_data === '0, "R2 rd_data after reset", rd_data, 0);
    rst_done = 1;

    // R4: reads on an empty FIFO do nothing
    rd_go = 1;
    repeat (6) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R4 still empty", rd_empty, 1);
    chk(rd_data === '0, "R4 no data read", rd_data, 0);
    rd_go = 0;
    repeat (2) @(negedge rd_clk);

    // R3/R5: fill without reads
    nacc = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      wr_try(8'(8'h40 + i), acc);
      if (acc) nacc++;
    end
    wr_idle();
    chk(nacc == DEPTH - 1, "R3 accepted writes", nacc, DEPTH - 1);
    chk(wr_full === 1'b1, "R5 full with DEPTH-1 words", wr_full, 1);
    chk(!rd_empty, "R5 not empty when full", rd_empty, 0);

    // drain: R6, R9 full clears
    rd_go = 1;
    wait (exp_q.size() == 0);
    repeat (4) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R6 empty after drain", rd_empty, 1);
    repeat (6) @(negedge wr_clk);
    chk(wr_full === 1'b0, "R9 full cleared", wr_full, 0);
    chk(got == DEPTH - 1, "R3 words delivered", got, DEPTH - 1);
    rd_go = 0;
    repeat (3) @(negedge rd_clk);

    // R9: empty-flag latency after a single write
    wr_try(8'hA5, acc);
    wr_idle();
    lat = 0;
    while (rd_empty && lat < 20) begin
      @(negedge rd_clk);
      lat++;
    end
    chk(lat <= 6, "R9 empty latency", lat, 6);
    rd_go = 1;
    wait (exp_q.size() == 0);
    repeat (4) @(negedge rd_clk);

    // R10: both ports active with random gaps
    rd_rand = 1;
    got = 0;
    for (int i = 0; i < 300; i++) begin
      acc = 0;
      while (!acc) begin
        lw = {lw[14:0], lw[15] ^ lw[13] ^ lw[12] ^ lw[10]};
        if (lw[1:0] == 2'b00) begin
          wr_idle();
        end else begin
          wr_try(8'(i * 7 + 3), acc);
        end
      end
    end
    wr_idle();
    wait (exp_q.size() == 0);
    repeat (6) @(negedge rd_clk);
    chk(got == 300, "R10 all words received", got, 300);
    chk(rd_empty === 1'b1, "R6 empty at end", rd_empty, 1);
    chk(wr_full === 1'b0, "R9 not full at end", wr_full, 0);
    rd_go = 0;
    repeat (4) @(negedge rd_clk);
    finish_run();
  end
endmodule